// File: doc/BRIEF.md
# Cell Sub-Port Address Extractor

This block sits on the receive side of a cell bridge that works as the ATM layer. Each cell arrives as a stream of bytes, with a marker on its first byte. Somewhere in the first part of the cell, which holds the prepend, header and user-defined bytes, the sending end has placed a three-bit sub-port number. Two runtime settings say where that number is. One gives the index of the byte that carries it. The other is a bit mask that picks three bits of that byte, in any positions.

The block watches the stream and waits for the configured byte. It gathers the three masked bits into a compact number. One clock later it presents that number together with the multi-PHY port address, which names the port. It also raises a single-cycle strobe and drives a one-hot select over the eight flow-control lanes of that port.

In PHY mode the sub-port field is not looked at, and the block stays quiet. Cell storage is handled elsewhere.

Top module: `subport_extractor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sub_vld`, `sub_id`, `lane_sel`, `port_out` and `cfg_err` are all zero.
- R2: Only cycles with `byte_vld` high count as bytes. The byte with `cell_sop` high has index 0, and each later valid byte adds one, saturating at 2^LOC_W-1. The byte whose index equals `loc_cfg` is the selected byte. At most one byte per cell is selected. No byte is selected before the first start of cell after reset.
- R3: `sub_id` is built from the selected byte's bits at the set positions of `mask_cfg`, taken from the lowest set position upward. The lowest masked bit becomes `sub_id[0]` and the highest becomes `sub_id[2]`.
- R4: `cfg_err` is 1 exactly when `mask_cfg` has a number of set bits other than three, one cycle after that mask is applied. While the mask is invalid, no strobe is produced.
- R5: `sub_vld` is high for exactly the one cycle after the selected byte is accepted. This needs ATM mode and a valid mask. The strobe is never high in any other cycle.
- R6: With the strobe, `lane_sel` equals 1 shifted left by `sub_id`. It holds that value until the cycle after the next start-of-cell byte, when it returns to 0. The exception is when that start-of-cell byte is itself the selected byte.
- R7: When `atm_mode` is 0 (PHY mode), no strobe is produced and `lane_sel`, `sub_id` and `port_out` do not change.
- R8: `port_out` takes the value of `port_addr` present with the selected byte. It is updated together with the strobe.
- R9: A cell that ends before reaching index `loc_cfg` produces no strobe, and `lane_sel` stays 0 after its start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| atm_mode | input | 1 | 1 = ATM-layer mode (extract), 0 = PHY mode (ignore field) |
| loc_cfg | input | LOC_W | Index of the byte holding the sub-port field |
| mask_cfg | input | DATA_W | Mask selecting the three field bits |
| port_addr | input | PORT_W | Multi-PHY port address of the current cell |
| byte_vld | input | 1 | Byte on `byte_data` is valid this cycle |
| cell_sop | input | 1 | Marks the first byte of a cell (qualified by `byte_vld`) |
| byte_data | input | DATA_W | Cell byte |
| sub_id | output | 3 | Extracted sub-port number |
| sub_vld | output | 1 | One-cycle strobe: new extraction result |
| lane_sel | output | 8 | One-hot lane select, held per cell |
| port_out | output | PORT_W | Port address latched with the extraction |
| cfg_err | output | 1 | Mask does not have exactly three set bits |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 6-bit byte index and a 5-bit port address. A six-bit index lets a 70-byte cell drive the counter into saturation at 63 and still select byte 63 only once. The 8-bit data width allows masks whose three bits are scattered, packed, or too few or too many. Random cells mix idle gaps, switches between ATM and PHY mode, and cells shorter than the selected index.

// File: rtl/subport_pkg.sv
`timescale 1ns/1ps
package subport_pkg;
  localparam int SUB_W     = 3;
  localparam int NUM_LANES = 1 << SUB_W;
endpackage

// File: rtl/byte_position_tracker.sv
`timescale 1ns/1ps
module byte_position_tracker #(
  parameter int LOC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic             cell_sop,
  input  logic [LOC_W-1:0] loc_cfg,
  output logic             hit
);
  localparam logic [LOC_W-1:0] IDX_MAX = '1;

  logic [LOC_W-1:0] nxt_idx;
  logic [LOC_W-1:0] cur_idx;
  logic             done;

  assign cur_idx = cell_sop ? '0 : nxt_idx;
  assign hit     = byte_vld && (cur_idx == loc_cfg) && (cell_sop || !done);

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_idx <= IDX_MAX;
      done    <= 1'b1;
    end else if (byte_vld) begin
      nxt_idx <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
      done    <= hit | (done & ~cell_sop);
    end
  end
endmodule

// File: rtl/mask_field_gather.sv
`timescale 1ns/1ps
module mask_field_gather
  import subport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_data,
  input  logic [DATA_W-1:0] mask_cfg,
  output logic [SUB_W-1:0]  field,
  output logic              mask_ok
);
  // Walk from the top bit down, shifting each masked bit in at the bottom,
  // so the lowest masked bit lands in field[0].
  always_comb begin
    field = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (mask_cfg[i]) field = {field[SUB_W-2:0], byte_data[i]};
    end
  end

  assign mask_ok = ($countones(mask_cfg) == SUB_W);
endmodule

// File: rtl/lane_select_reg.sv
`timescale 1ns/1ps
module lane_select_reg
  import subport_pkg::*;
#(
  parameter int PORT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 clear,
  input  logic [SUB_W-1:0]     field,
  input  logic [PORT_W-1:0]    port_in,
  output logic [SUB_W-1:0]     sub_id,
  output logic                 sub_vld,
  output logic [NUM_LANES-1:0] lane_sel,
  output logic [PORT_W-1:0]    port_out
);
  logic [NUM_LANES-1:0] lane_dec;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_dec
    assign lane_dec[g] = (field == g[SUB_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_id   <= '0;
      sub_vld  <= 1'b0;
      lane_sel <= '0;
      port_out <= '0;
    end else begin
      sub_vld <= load;
      if (load) begin
        sub_id   <= field;
        port_out <= port_in;
        lane_sel <= lane_dec;
      end else if (clear) begin
        lane_sel <= '0;
      end
    end
  end
endmodule

// File: rtl/subport_extractor.sv
`timescale 1ns/1ps
module subport_extractor
  import subport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOC_W  = 6,
  parameter int PORT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 atm_mode,
  input  logic [LOC_W-1:0]     loc_cfg,
  input  logic [DATA_W-1:0]    mask_cfg,
  input  logic [PORT_W-1:0]    port_addr,
  input  logic                 byte_vld,
  input  logic                 cell_sop,
  input  logic [DATA_W-1:0]    byte_data,
  output logic [SUB_W-1:0]     sub_id,
  output logic                 sub_vld,
  output logic [NUM_LANES-1:0] lane_sel,
  output logic [PORT_W-1:0]    port_out,
  output logic                 cfg_err
);
  logic             hit;
  logic [SUB_W-1:0] field;
  logic             mask_ok;
  logic             load;
  logic             clear;

  byte_position_tracker #(.LOC_W(LOC_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .byte_vld (byte_vld),
    .cell_sop (cell_sop),
    .loc_cfg  (loc_cfg),
    .hit      (hit)
  );

  mask_field_gather #(.DATA_W(DATA_W)) u_gather (
    .byte_data (byte_data),
    .mask_cfg  (mask_cfg),
    .field     (field),
    .mask_ok   (mask_ok)
  );

  assign load  = hit && atm_mode && mask_ok;
  assign clear = byte_vld && cell_sop && atm_mode;

  lane_select_reg #(.PORT_W(PORT_W)) u_lane (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .clear    (clear),
    .field    (field),
    .port_in  (port_addr),
    .sub_id   (sub_id),
    .sub_vld  (sub_vld),
    .lane_sel (lane_sel),
    .port_out (port_out)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= !mask_ok;
  end
endmodule

// File: rtl/subport_extractor_chk.sv
`timescale 1ns/1ps
module subport_extractor_chk
  import subport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOC_W  = 6,
  parameter int PORT_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 atm_mode,
  input logic                 byte_vld,
  input logic                 cell_sop,
  input logic [SUB_W-1:0]     sub_id,
  input logic                 sub_vld,
  input logic [NUM_LANES-1:0] lane_sel,
  input logic [PORT_W-1:0]    port_out,
  input logic                 cfg_err
);
  assert_lane_onehot0_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_sel));

  assert_lane_matches_id_R6: assert property (@(posedge clk) disable iff (rst)
    sub_vld |-> (lane_sel[sub_id] && $onehot(lane_sel)));

  assert_lane_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && cell_sop && atm_mode) |=> (sub_vld || lane_sel == '0));

  assert_lane_held_R6: assert property (@(posedge clk) disable iff (rst)
    !(byte_vld && cell_sop) |=> (sub_vld || $stable(lane_sel)));

  assert_no_strobe_on_err_R4: assert property (@(posedge clk) disable iff (rst)
    sub_vld |-> !cfg_err);

  assert_strobe_follows_byte_R5: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |=> !sub_vld);

  assert_phy_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !atm_mode |=> (!sub_vld && $stable(lane_sel) && $stable(port_out)));
endmodule

bind subport_extractor subport_extractor_chk #(
  .DATA_W(DATA_W), .LOC_W(LOC_W), .PORT_W(PORT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .atm_mode (atm_mode),
  .byte_vld (byte_vld),
  .cell_sop (cell_sop),
  .sub_id   (sub_id),
  .sub_vld  (sub_vld),
  .lane_sel (lane_sel),
  .port_out (port_out),
  .cfg_err  (cfg_err)
);

// File: tb/sim_subport_extractor.sv
`timescale 1ns/1ps
module sim_subport_extractor;
  localparam int DATA_W = 8;
  localparam int LOC_W  = 6;
  localparam int PORT_W = 5;
  localparam int IDX_MAX = (1 << LOC_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              atm_mode = 1'b1;
  logic [LOC_W-1:0]  loc_cfg = '0;
  logic [DATA_W-1:0] mask_cfg = 8'h07;
  logic [PORT_W-1:0] port_addr = '0;
  logic              byte_vld = 1'b0;
  logic              cell_sop = 1'b0;
  logic [DATA_W-1:0] byte_data = '0;
  logic [2:0]        sub_id;
  logic              sub_vld;
  logic [7:0]        lane_sel;
  logic [PORT_W-1:0] port_out;
  logic              cfg_err;

  int checks = 0;
  int errors = 0;

  // bench model state
  int         m_idx = IDX_MAX;
  bit         m_done = 1'b1;
  logic [7:0] m_lane = '0;
  logic [2:0] m_id = '0;
  logic [PORT_W-1:0] m_port = '0;

  always #4 clk = ~clk;

  subport_extractor #(.DATA_W(DATA_W), .LOC_W(LOC_W), .PORT_W(PORT_W)) u0 (
    .clk(clk), .rst(rst), .atm_mode(atm_mode), .loc_cfg(loc_cfg),
    .mask_cfg(mask_cfg), .port_addr(port_addr), .byte_vld(byte_vld),
    .cell_sop(cell_sop), .byte_data(byte_data), .sub_id(sub_id),
    .sub_vld(sub_vld), .lane_sel(lane_sel), .port_out(port_out),
    .cfg_err(cfg_err)
  );

  function automatic int ones(input logic [7:0] m);
    int n = 0;
    for (int j = 0; j < 8; j++) n += int'(m[j]);
    return n;
  endfunction

  function automatic logic [2:0] gather(input logic [7:0] d, input logic [7:0] m);
    logic [2:0] v = '0;
    int k = 0;
    for (int j = 0; j < 8; j++) begin
      if (m[j]) begin
        if (k < 3) v = v | (3'(d[j]) << k);
        k++;
      end
    end
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle of stimulus, then compare against the model after the edge
  task automatic step(input bit v, input bit s, input logic [7:0] d);
    int  cur;
    bit  hit;
    bit  ev;
    @(negedge clk);
    byte_vld  = v;
    cell_sop  = s;
    byte_data = d;
    port_addr = PORT_W'($urandom);
    hit = 1'b0;
    if (v) begin
      cur = s ? 0 : m_idx;
      hit = (cur == int'(loc_cfg)) && (s || !m_done);
      m_done = hit || (m_done && !s);
      m_idx = (cur == IDX_MAX) ? IDX_MAX : cur + 1;
      if (s && atm_mode) m_lane = '0;
    end
    ev = hit && atm_mode && (ones(mask_cfg) == 3);
    if (ev) begin
      m_id   = gather(d, mask_cfg);
      m_lane = 8'(1) << m_id;
      m_port = port_addr;
    end
    @(posedge clk);
    #1;
    chk("R5 sub_vld", int'(sub_vld), int'(ev));
    chk("R4 cfg_err", int'(cfg_err), int'(ones(mask_cfg) != 3));
    chk("R6 lane_sel", int'(lane_sel), int'(m_lane));
    chk("R7/R3 sub_id", int'(sub_id), int'(m_id));
    chk("R8 port_out", int'(port_out), int'(m_port));
  endtask

  task automatic send_cell(input int len, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) step(1'b0, 1'b0, 8'($urandom));
      step(1'b1, i == 0, 8'($urandom));
    end
  endtask

  task automatic one_byte_cell(input logic [7:0] d0);
    step(1'b1, 1'b1, d0);
    step(1'b1, 1'b0, 8'($urandom));
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset sub_vld", int'(sub_vld), 0);
    chk("R1 reset lane_sel", int'(lane_sel), 0);
    chk("R1 reset cfg_err", int'(cfg_err), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 after reset lane_sel", int'(lane_sel), 0);
    chk("R1 after reset port_out", int'(port_out), 0);

    // R2: bytes before first start of cell are never selected
    loc_cfg = 0;
    step(1'b1, 1'b0, 8'hFF);
    step(1'b1, 1'b0, 8'hFF);

    // R3: packed low mask, byte 0
    mask_cfg = 8'h07;
    one_byte_cell(8'h05);
    chk("R3 directed low mask", int'(sub_id), 5);
    // R3: scattered mask bits 2,5,7
    mask_cfg = 8'hA4;
    one_byte_cell(8'h84);
    chk("R3 scattered 0x84", int'(sub_id), 5);
    one_byte_cell(8'h20);
    chk("R3 scattered 0x20", int'(sub_id), 2);
    chk("R6 lane for 2", int'(lane_sel), 8'h04);

    // R2: selected byte later in cell, with gaps
    loc_cfg = 5;
    mask_cfg = 8'hE0;
    send_cell(12, 1'b1);

    // R4: invalid masks
    mask_cfg = 8'h0F;
    send_cell(8, 1'b0);
    chk("R4 four bits", int'(cfg_err), 1);
    mask_cfg = 8'h01;
    send_cell(8, 1'b0);

    // R7: PHY mode
    mask_cfg = 8'h70;
    atm_mode = 1'b0;
    send_cell(10, 1'b1);
    atm_mode = 1'b1;

    // R9: cell shorter than location
    loc_cfg = 20;
    send_cell(10, 1'b0);
    chk("R9 short cell lane", int'(lane_sel), 0);

    // R2: index saturation, selected byte at max index only once
    loc_cfg = LOC_W'(IDX_MAX);
    mask_cfg = 8'h38;
    send_cell(70, 1'b0);

    // random mix
    for (int c = 0; c < 300; c++) begin
      loc_cfg = LOC_W'($urandom % 16);
      if ($urandom % 8 == 0) mask_cfg = 8'($urandom);
      else begin
        logic [7:0] m = '0;
        while (ones(m) < 3) m[$urandom % 8] = 1'b1;
        mask_cfg = m;
      end
      atm_mode = ($urandom % 6) != 0;
      send_cell(2 + int'($urandom % 20), ($urandom % 2) == 1);
    end

    step(1'b0, 1'b0, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule